// File: doc/BRIEF.md
# DMA Interrupt Flag Register Bank

This block keeps the sticky event flags of an eight-channel DMA engine and turns them into one interrupt line per channel. Every channel feeds five event strobes into the bank: FIFO error, single-data error, transfer-access error, half-transfer done and full-transfer done. A strobe sets the matching flag, and the flag stays set until software clears it.

Software reaches the bank over a simple 32-bit register port with a combinational read path. Two read-only flag words each hold four channels. Channel fields sit at offsets that are not evenly spaced. Two write-one-to-clear words mirror the flag words bit for bit. One enable word holds four event enables for each channel. A separate per-channel input gates the FIFO error flag. A channel's interrupt line stays high while any of its enabled flags is set.

Top module: `dmaf_bank`

## Requirements
- R1: Word address 0 holds channels 0-3 and word address 1 holds channels 4-7. A channel with local index l = channel mod 4 has its field start at bit l*8 - (l mod 2)*2, so the offsets are 0, 6, 16 and 22. Within a field the bits are: bit 0 FIFO error, bit 2 single-data error, bit 3 transfer-access error, bit 4 half-transfer, bit 5 full-transfer.
- R2: Field bit 1 and every bit outside the four fields read as 0 in both flag words.
- R3: An event strobe on evt_i (channel c, event k at bit c*5+k, with k in the order FIFO, single-data, transfer-access, half, full) that is high at a rising edge sets its flag. The flag then stays set after the strobe drops.
- R4: Writing to word address 2 or 3 clears each flag of flag word 0 or 1 whose bit position carries a 1. Flags at positions written 0 are left unchanged.
- R5: If an event strobe and a clear hit the same flag at the same edge, the flag ends up set.
- R6: Word address 4 is a read/write enable word. Channel c owns bits 4c to 4c+3, which enable single-data, transfer-access, half-transfer and full-transfer in that order.
- R7: irq_o[c] is high exactly while at least one of these holds: an enabled flag of channel c is set, or its FIFO error flag is set while fifo_en_i[c] is 1. The line falls once the flags are cleared or the enables are removed.
- R8: Reads of the clear words return 0. Writes to the flag words and to unmapped addresses 5-7 change no state.
- R9: While rst_ni is low, all flags and all enables are cleared and every irq_o bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 when there is no read |
| evt_i | input | 40 | Event strobes, five per channel |
| fifo_en_i | input | 8 | Per-channel FIFO error interrupt enable |
| irq_o | output | 8 | Per-channel interrupt lines |

## Verification
The bench builds the bank with its defaults: eight channels, four per word and 32-bit data. This places both odd-channel offsets (6 and 22) and the second word pair under test. With these values every flag position in both words can be set and cleared, and all eight irq lines can be watched against a model of flags and enables. The same-edge set/clear collision and the FIFO enable path are driven directly through the ports.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;
  localparam int NUM_EV   = 5;  // fifo, sde, tae, htf, ftf
  localparam int CTL_EN_W = 4;  // sde, tae, htf, ftf

  // start bit of a channel field within its word
  function automatic int field_off(input int l);
    return l * 8 - (l % 2) * 2;
  endfunction

  // bit of event k inside a field; bit 1 is reserved
  function automatic int ev_pos(input int k);
    return (k == 0) ? 0 : k + 1;
  endfunction
endpackage

// File: rtl/dmaf_chan.sv
module dmaf_chan #(
  parameter int NUM_EV = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] set_i,
  input  logic [NUM_EV-1:0] clr_i,
  input  logic [NUM_EV-1:0] en_i,
  output logic [NUM_EV-1:0] flag_o,
  output logic              irq_o
);
  logic [NUM_EV-1:0] flag_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);
endmodule

// File: rtl/dmaf_regif.sv
module dmaf_regif
  import dmaf_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int CH_PER_REG = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  localparam int NUM_REG   = NUM_CH / CH_PER_REG,
  localparam int FLAG_W    = NUM_CH * NUM_EV,
  localparam int EN_W      = NUM_CH * CTL_EN_W,
  localparam int EN_ADDR   = 2 * NUM_REG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [FLAG_W-1:0] flag_i,
  output logic [FLAG_W-1:0] clr_o,
  output logic [EN_W-1:0]   ctl_en_o
);
  logic [NUM_REG-1:0] clr_wr;
  logic [DATA_W-1:0]  flag_word [NUM_REG];
  logic [EN_W-1:0]    en_q;
  logic               en_wr;

  always_comb begin
    for (int r = 0; r < NUM_REG; r++)
      clr_wr[r] = req_i & we_i & (addr_i == ADDR_W'(NUM_REG + r));
  end

  assign en_wr = req_i & we_i & (addr_i == ADDR_W'(EN_ADDR));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar k = 0; k < NUM_EV; k++) begin : g_ev
      localparam int POS = field_off(c % CH_PER_REG) + ev_pos(k);
      assign clr_o[c*NUM_EV+k] = clr_wr[c/CH_PER_REG] & wdata_i[POS];
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_REG; r++) flag_word[r] = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int k = 0; k < NUM_EV; k++)
        flag_word[c/CH_PER_REG][field_off(c % CH_PER_REG) + ev_pos(k)] = flag_i[c*NUM_EV+k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_wr) en_q <= wdata_i[EN_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      for (int r = 0; r < NUM_REG; r++)
        if (addr_i == ADDR_W'(r)) rdata_o = flag_word[r];
      if (addr_i == ADDR_W'(EN_ADDR)) rdata_o = DATA_W'(en_q);
    end
  end

  assign ctl_en_o = en_q;
endmodule

// File: rtl/dmaf_bank.sv
module dmaf_bank
  import dmaf_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int CH_PER_REG = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  localparam int FLAG_W    = NUM_CH * NUM_EV,
  localparam int EN_W      = NUM_CH * CTL_EN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [FLAG_W-1:0] evt_i,
  input  logic [NUM_CH-1:0] fifo_en_i,
  output logic [NUM_CH-1:0] irq_o
);
  logic [FLAG_W-1:0] flag_w;
  logic [FLAG_W-1:0] clr_w;
  logic [EN_W-1:0]   ctl_en_w;

  dmaf_regif #(
    .NUM_CH(NUM_CH), .CH_PER_REG(CH_PER_REG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regif (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .flag_i(flag_w), .clr_o(clr_w), .ctl_en_o(ctl_en_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [NUM_EV-1:0] en;
    assign en = {ctl_en_w[c*CTL_EN_W +: CTL_EN_W], fifo_en_i[c]};
    dmaf_chan #(.NUM_EV(NUM_EV)) u_chan (
      .clk_i, .rst_ni,
      .set_i (evt_i[c*NUM_EV +: NUM_EV]),
      .clr_i (clr_w[c*NUM_EV +: NUM_EV]),
      .en_i  (en),
      .flag_o(flag_w[c*NUM_EV +: NUM_EV]),
      .irq_o (irq_o[c])
    );
  end
endmodule

// File: rtl/dmaf_bank_chk.sv
module dmaf_bank_chk
  import dmaf_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int CH_PER_REG = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  localparam int NUM_REG   = NUM_CH / CH_PER_REG,
  localparam int FLAG_W    = NUM_CH * NUM_EV
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [FLAG_W-1:0] evt_i,
  input logic [NUM_CH-1:0] irq_o,
  input logic [FLAG_W-1:0] flag_w,
  input logic [FLAG_W-1:0] clr_w
);
  logic pv;
  logic [DATA_W-1:0] live_mask;
  logic rd_flag, rd_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv <= 1'b0;
    else         pv <= 1'b1;
  end

  always_comb begin
    live_mask = '0;
    for (int l = 0; l < CH_PER_REG; l++)
      for (int k = 0; k < NUM_EV; k++)
        live_mask[field_off(l) + ev_pos(k)] = 1'b1;
  end

  assign rd_flag = req_i && !we_i && (addr_i < ADDR_W'(NUM_REG));
  assign rd_clr  = req_i && !we_i && (addr_i >= ADDR_W'(NUM_REG)) &&
                   (addr_i < ADDR_W'(2 * NUM_REG));

  a_r3_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv |-> ((flag_w & $past(evt_i)) == $past(evt_i)));

  a_r4_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv |-> ((flag_w & $past(clr_w & ~evt_i)) == '0));

  a_r3_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv |-> ((flag_w & ~$past(clr_w | evt_i)) == ($past(flag_w) & ~$past(clr_w | evt_i))));

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_flag |-> ((rdata_o & ~live_mask) == '0));

  a_r8_clr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr |-> (rdata_o == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
    a_r7_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (|flag_w[c*NUM_EV +: NUM_EV]));
  end
endmodule

bind dmaf_bank dmaf_bank_chk #(
  .NUM_CH(NUM_CH), .CH_PER_REG(CH_PER_REG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .evt_i(evt_i), .irq_o(irq_o), .flag_w(flag_w), .clr_w(clr_w)
);

// File: tb/sim_dmaf_bank.sv
`timescale 1ns/1ps
module sim_dmaf_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [39:0] evt = '0;
  logic [7:0]  fifo_en = '0;
  logic [7:0]  irq;

  logic [39:0] exp_f = '0;
  logic [31:0] exp_en = '0;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dmaf_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .fifo_en_i(fifo_en), .irq_o(irq)
  );

  function automatic int pos_of(input int k);
    return (k == 0) ? 0 : k + 1;
  endfunction

  function automatic logic [31:0] exp_word(input int r);
    logic [31:0] w = '0;
    for (int l = 0; l < 4; l++) begin
      int c = r * 4 + l;
      int off = l * 8 - (l % 2) * 2;
      for (int k = 0; k < 5; k++) w[off + pos_of(k)] = exp_f[c*5+k];
    end
    return w;
  endfunction

  function automatic logic [7:0] exp_irq();
    logic [7:0] x;
    for (int c = 0; c < 8; c++)
      x[c] = (exp_f[c*5] & fifo_en[c]) | (|(exp_f[c*5+1 +: 4] & exp_en[c*4 +: 4]));
    return x;
  endfunction

  task automatic clr_model(input int r, input logic [31:0] d);
    for (int l = 0; l < 4; l++) begin
      int c = r * 4 + l;
      int off = l * 8 - (l % 2) * 2;
      for (int k = 0; k < 5; k++) if (d[off + pos_of(k)]) exp_f[c*5+k] = 1'b0;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic pulse(input logic [39:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
    exp_f = exp_f | v;
  endtask

  task automatic check_flags(input string tag);
    logic [31:0] d;
    bus_read(3'd0, d); check({tag, " word0"}, d, exp_word(0));
    bus_read(3'd1, d); check({tag, " word1"}, d, exp_word(1));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      bus_read(3'(a), d);
      check("R9 reset read", d, 32'h0);
    end
    check("R9 reset irq", {24'h0, irq}, 32'h0);
  endtask

  task automatic t_pack();
    logic [39:0] v = '0;
    for (int c = 0; c < 8; c++) v[c*5 +: 5] = 5'(c * 3 + 1);
    pulse(v);
    check_flags("R1 distinct pattern");
    pulse(40'h00_0000_0842);
    check_flags("R3 sticky or");
    pulse('1);
    check_flags("R2 all set");
    bus_write(3'd2, 32'hFFFF_FFFF); clr_model(0, 32'hFFFF_FFFF);
    bus_write(3'd3, 32'hFFFF_FFFF); clr_model(1, 32'hFFFF_FFFF);
    check_flags("R4 clear all");
  endtask

  task automatic t_clear();
    pulse('1);
    bus_write(3'd2, 32'h0000_0FC0); clr_model(0, 32'h0000_0FC0);
    bus_write(3'd3, 32'h0);
    check_flags("R4 partial clear");
    bus_write(3'd3, 32'h0000_0024); clr_model(1, 32'h0000_0024);
    check_flags("R4 selected bits");
  endtask

  task automatic t_set_wins();
    pulse('1);
    @(negedge clk);
    evt = 40'h1 << 14;
    req = 1'b1; we = 1'b1; addr = 3'd2; wdata = (32'h1 << 21) | (32'h1 << 20);
    @(negedge clk);
    evt = '0; req = 1'b0; we = 1'b0; wdata = '0;
    clr_model(0, (32'h1 << 21) | (32'h1 << 20));
    exp_f[14] = 1'b1;
    check_flags("R5 set beats clear");
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_write(3'd2, '1); bus_write(3'd3, '1); exp_f = '0;
    exp_en = (32'h4 << 12) | (32'hF << 20);
    bus_write(3'd4, exp_en);
    bus_read(3'd4, d); check("R6 enable readback", d, exp_en);
    fifo_en = 8'h01;
    pulse(40'h1 << 19);
    #1 check("R7 disabled event no irq", {24'h0, irq}, {24'h0, exp_irq()});
    pulse(40'h1 << 18);
    #1 check("R7 htf irq ch3", {24'h0, irq}, {24'h0, exp_irq()});
    pulse(40'h1 | (40'h1 << 26));
    #1 check("R7 fifo and sde irq", {24'h0, irq}, {24'h0, exp_irq()});
    @(negedge clk); fifo_en = 8'h00;
    #1 check("R7 fifo enable removed", {24'h0, irq}, {24'h0, exp_irq()});
    bus_write(3'd2, 32'h3F << 22); clr_model(0, 32'h3F << 22);
    #1 check("R7 cleared ch3", {24'h0, irq}, {24'h0, exp_irq()});
    bus_write(3'd4, 32'h0); exp_en = '0;
    #1 check("R7 enables removed", {24'h0, irq}, {24'h0, exp_irq()});
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    pulse(40'h00_F0F0_0F0F);
    bus_write(3'd4, 32'hA5A5_A5A5); exp_en = 32'hA5A5_A5A5;
    bus_write(3'd0, 32'hFFFF_FFFF);
    bus_write(3'd1, 32'hFFFF_FFFF);
    check_flags("R8 flag word write ignored");
    bus_read(3'd2, d); check("R8 clear word0 reads 0", d, 32'h0);
    bus_read(3'd3, d); check("R8 clear word1 reads 0", d, 32'h0);
    bus_write(3'd7, 32'h0); bus_write(3'd5, 32'h0);
    bus_read(3'd4, d); check("R8 unmapped write ignored", d, exp_en);
  endtask

  task automatic t_reset_mid();
    logic [31:0] d;
    fifo_en = 8'hFF;
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    exp_f = '0; exp_en = '0;
    check("R9 irq in reset", {24'h0, irq}, 32'h0);
    rst_ni = 1'b1;
    check_flags("R9 flags after reset");
    bus_read(3'd4, d); check("R9 enables after reset", d, 32'h0);
    fifo_en = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    fork
      begin
        t_reset();
        t_pack();
        t_clear();
        t_set_wins();
        t_irq();
        t_ignored();
        t_reset_mid();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule